// File: doc/BRIEF.md
# Streaming Template Correlator

This block scores a stream of binned neural-activity counts against a small set of stored activity templates. It keeps one processing element per template, each sitting beside its own template memory. Every arriving element is tagged with its channel and bin. All processing elements read the template entry for that position in the same cycle and fold the product into a running integer sum. No input matrix is ever buffered, and the work for a frame is finished one cycle after its last element lands.

Once the last element has been accumulated, a post-processing stage visits the templates one per cycle. It forms each template's Pearson numerator `N*Sum(x*t) - Sum(x)*Sum(t)`, where `N = NUM_CH*NUM_BINS`. It ranks the templates by correlation without a square root or a divide, and then pulses `done` with the winning index and that winner's numerator. The template-only sums `Sum(t)` and `Sum(t*t)` are computed off-line and written with the template. The input variance is the same for every template, so it is left out of the ranking.

Top module: `tc_correlator`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `done` is 0, `best_idx` is 0 and `best_num` is 0.
- R2: A write with `tw_en` stores `tw_data` as the entry of template `tw_sel` at element `tw_addr`. Element e means channel `e % NUM_CH` and bin `e / NUM_CH`. A write with `ts_en` stores `ts_sum_t` and `ts_sum_tt` as the precomputed sums of template `ts_sel`.
- R3: `best_num` equals `N*Sum(x*t) - Sum(x)*Sum(t)` for the winning template, taken over all N elements. Any element that is never presented counts as zero.
- R4: The winner is the template with the highest correlation `num / sqrt(den)`, where `den = N*Sum(t*t) - Sum(t)^2`.
- R5: A positive numerator always beats a zero numerator, and a zero numerator always beats a negative one. Among negative numerators, the one with the smallest magnitude of correlation wins.
- R6: When correlations are exactly equal, the lower template index wins.
- R7: `done` is a one-cycle pulse. It rises exactly `NUM_TMPL+2` clock edges after the edge that accepts the last element. `best_idx` and `best_num` change only on that edge.
- R8: An accepted `frame_start` clears the input sums. An element accepted in the same cycle counts as the first element of the new frame.
- R9: An element whose channel is `NUM_CH` or higher, or whose bin is `NUM_BINS` or higher, is dropped entirely, including its last-element flag.
- R10: From the edge after the last element is accepted until `done` rises, `frame_start` and `in_valid` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tw_en | input | 1 | Template element write strobe |
| tw_sel | input | TSEL_W | Template selected for the element write |
| tw_addr | input | AW | Element index `bin*NUM_CH + channel` |
| tw_data | input | TW | Template value |
| ts_en | input | 1 | Template sums write strobe |
| ts_sel | input | TSEL_W | Template selected for the sums write |
| ts_sum_t | input | TW+CL | Precomputed Sum(t) |
| ts_sum_tt | input | 2*TW+CL | Precomputed Sum(t*t) |
| frame_start | input | 1 | Clears the input sums |
| in_valid | input | 1 | Binned element present |
| in_ch | input | CH_W | Channel of the element |
| in_bin | input | BIN_W | Bin of the element |
| in_val | input | XW | Binned count |
| in_last | input | 1 | Marks the final element of a frame |
| done | output | 1 | One-cycle result pulse |
| best_idx | output | TSEL_W | Winning template index |
| best_num | output | NUM_W | Signed numerator of the winner |

## Verification
The bench aims at the ranking corner cases. Two identical templates must both match the input; a design that let the later one win would report index 3 instead of 1. A constant template with a zero numerator competes against anti-correlated templates, and a design that ranked by squared ratio alone would pick a negative one. Frames are sent sparsely, with gaps, and with the frame start folded into the first element; an off-by-one in clearing or addressing shifts `best_num`. Strobes injected during ranking are followed by a zero-valued re-rank of the same sums, so a design that let any of them through reports a different numerator. An out-of-range element carrying the last flag must not trigger a result.

// File: rtl/tc_pkg.sv
`timescale 1ns/1ps
package tc_pkg;
  typedef enum logic [1:0] {PH_ACCUM, PH_RANK, PH_REPORT} phase_e;
  typedef enum logic [1:0] {SG_NEG = 2'd0, SG_ZERO = 2'd1, SG_POS = 2'd2} sign_e;
endpackage

// File: rtl/tc_input_stage.sv
`timescale 1ns/1ps
module tc_input_stage #(
  parameter int NUM_CH   = 3,
  parameter int NUM_BINS = 4,
  parameter int XW       = 4,
  parameter int AW       = 4,
  parameter int CH_W     = 2,
  parameter int BIN_W    = 2,
  parameter int SX_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy,
  input  logic             frame_start,
  input  logic             in_valid,
  input  logic [CH_W-1:0]  in_ch,
  input  logic [BIN_W-1:0] in_bin,
  input  logic [XW-1:0]    in_val,
  input  logic             in_last,
  output logic             rd_en,
  output logic [AW-1:0]    rd_addr,
  output logic             el_vld,
  output logic             el_clr,
  output logic             el_last,
  output logic [XW-1:0]    el_x,
  output logic [SX_W-1:0]  sum_x
);
  logic in_range;

  always_comb begin
    in_range = (int'(in_ch) < NUM_CH) && (int'(in_bin) < NUM_BINS);
    rd_en    = in_valid && in_range && !busy;
    rd_addr  = AW'(in_bin) * AW'(NUM_CH) + AW'(in_ch);
  end

  // one pipeline stage, aligned with the synchronous template read
  always_ff @(posedge clk) begin
    if (rst) begin
      el_vld  <= 1'b0;
      el_clr  <= 1'b0;
      el_last <= 1'b0;
      el_x    <= '0;
    end else begin
      el_vld  <= rd_en;
      el_clr  <= frame_start && !busy;
      el_last <= rd_en && in_last;
      el_x    <= in_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      sum_x <= '0;
    else if (el_clr)
      sum_x <= el_vld ? SX_W'(el_x) : '0;
    else if (el_vld)
      sum_x <= sum_x + SX_W'(el_x);
  end
endmodule

// File: rtl/tc_pe.sv
`timescale 1ns/1ps
module tc_pe #(
  parameter int N_ELEM = 12,
  parameter int XW     = 4,
  parameter int TW     = 4,
  parameter int AW     = 4,
  parameter int SXT_W  = 12,
  parameter int ST_W   = 8,
  parameter int STT_W  = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [TW-1:0]    wr_data,
  input  logic             st_en,
  input  logic [ST_W-1:0]  st_sum_t,
  input  logic [STT_W-1:0] st_sum_tt,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  input  logic             el_vld,
  input  logic             el_clr,
  input  logic [XW-1:0]    el_x,
  output logic [SXT_W-1:0] sum_xt,
  output logic [ST_W-1:0]  sum_t,
  output logic [STT_W-1:0] sum_tt
);
  localparam int PW = XW + TW;

  logic [TW-1:0] mem [N_ELEM];
  logic [TW-1:0] t_q;
  logic [PW-1:0] prod;

  // simple dual-port template store, registered read
  always_ff @(posedge clk) begin
    if (wr_en && (int'(wr_addr) < N_ELEM))
      mem[wr_addr] <= wr_data;
    if (rd_en)
      t_q <= mem[rd_addr];
  end

  always_comb prod = PW'(el_x) * PW'(t_q);

  always_ff @(posedge clk) begin
    if (rst)
      sum_xt <= '0;
    else if (el_clr)
      sum_xt <= el_vld ? SXT_W'(prod) : '0;
    else if (el_vld)
      sum_xt <= sum_xt + SXT_W'(prod);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_t  <= '0;
      sum_tt <= '0;
    end else if (st_en) begin
      sum_t  <= st_sum_t;
      sum_tt <= st_sum_tt;
    end
  end
endmodule

// File: rtl/tc_ranker.sv
`timescale 1ns/1ps
module tc_ranker
  import tc_pkg::*;
#(
  parameter int NT     = 4,
  parameter int N_ELEM = 12,
  parameter int TSEL_W = 2,
  parameter int SX_W   = 8,
  parameter int SXT_W  = 12,
  parameter int ST_W   = 8,
  parameter int STT_W  = 12,
  parameter int NUM_W  = 17,
  parameter int DEN_W  = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic [SX_W-1:0]               sum_x,
  input  logic [NT-1:0][SXT_W-1:0]      sum_xt,
  input  logic [NT-1:0][ST_W-1:0]       sum_t,
  input  logic [NT-1:0][STT_W-1:0]      sum_tt,
  output logic                          busy,
  output phase_e                        phase_o,
  output logic                          done,
  output logic [TSEL_W-1:0]             best_idx,
  output logic signed [NUM_W-1:0]       best_num
);
  localparam int PROD_W = 2 * NUM_W + DEN_W;

  phase_e                   phase;
  logic [TSEL_W-1:0]        k;
  logic signed [NUM_W-1:0]  cur_num;
  logic signed [NUM_W-1:0]  cand_num;
  logic [DEN_W-1:0]         cur_den;
  logic [DEN_W-1:0]         cand_den;
  logic [TSEL_W-1:0]        cand_idx;
  logic                     take;

  function automatic sign_e sign_of(input logic signed [NUM_W-1:0] n);
    if (n > 0) return SG_POS;
    if (n == 0) return SG_ZERO;
    return SG_NEG;
  endfunction

  // true when (an, ad) has a strictly higher correlation than (bn, bd)
  function automatic logic beats(input logic signed [NUM_W-1:0] an, input logic [DEN_W-1:0] ad,
                                 input logic signed [NUM_W-1:0] bn, input logic [DEN_W-1:0] bd);
    sign_e             ca, cb;
    logic [NUM_W-1:0]  am, bm;
    logic [PROD_W-1:0] lhs, rhs;
    ca  = sign_of(an);
    cb  = sign_of(bn);
    am  = (an < 0) ? $unsigned(-an) : $unsigned(an);
    bm  = (bn < 0) ? $unsigned(-bn) : $unsigned(bn);
    lhs = PROD_W'(am) * PROD_W'(am) * PROD_W'(bd);
    rhs = PROD_W'(bm) * PROD_W'(bm) * PROD_W'(ad);
    if (ca != cb) return (ca > cb);
    if (ca == SG_POS) return (lhs > rhs);
    if (ca == SG_NEG) return (lhs < rhs);
    return 1'b0;
  endfunction

  always_comb begin
    cur_num = $signed(NUM_W'(N_ELEM) * NUM_W'(sum_xt[k]) - NUM_W'(sum_x) * NUM_W'(sum_t[k]));
    cur_den = DEN_W'(N_ELEM) * DEN_W'(sum_tt[k]) - DEN_W'(sum_t[k]) * DEN_W'(sum_t[k]);
    take    = (k == '0) || beats(cur_num, cur_den, cand_num, cand_den);
    busy    = start || (phase != PH_ACCUM);
    phase_o = phase;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_ACCUM;
      k        <= '0;
      cand_num <= '0;
      cand_den <= '0;
      cand_idx <= '0;
      done     <= 1'b0;
      best_idx <= '0;
      best_num <= '0;
    end else begin
      done <= 1'b0;
      case (phase)
        PH_ACCUM: begin
          if (start) begin
            phase <= PH_RANK;
            k     <= '0;
          end
        end
        PH_RANK: begin
          if (take) begin
            cand_num <= cur_num;
            cand_den <= cur_den;
            cand_idx <= k;
          end
          if (int'(k) == NT - 1) phase <= PH_REPORT;
          else                   k     <= k + TSEL_W'(1);
        end
        PH_REPORT: begin
          done     <= 1'b1;
          best_idx <= cand_idx;
          best_num <= cand_num;
          phase    <= PH_ACCUM;
        end
        default: phase <= PH_ACCUM;
      endcase
    end
  end
endmodule

// File: rtl/tc_correlator.sv
`timescale 1ns/1ps
module tc_correlator
  import tc_pkg::*;
#(
  parameter int NUM_TMPL = 4,
  parameter int NUM_CH   = 3,
  parameter int NUM_BINS = 4,
  parameter int XW       = 4,
  parameter int TW       = 4,
  localparam int N_ELEM  = NUM_CH * NUM_BINS,
  localparam int CL      = $clog2(N_ELEM + 1),
  localparam int AW      = (N_ELEM > 1) ? $clog2(N_ELEM) : 1,
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int BIN_W   = (NUM_BINS > 1) ? $clog2(NUM_BINS) : 1,
  localparam int TSEL_W  = (NUM_TMPL > 1) ? $clog2(NUM_TMPL) : 1,
  localparam int ST_W    = TW + CL,
  localparam int STT_W   = 2 * TW + CL,
  localparam int NUM_W   = XW + TW + 2 * CL + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tw_en,
  input  logic [TSEL_W-1:0]       tw_sel,
  input  logic [AW-1:0]           tw_addr,
  input  logic [TW-1:0]           tw_data,
  input  logic                    ts_en,
  input  logic [TSEL_W-1:0]       ts_sel,
  input  logic [ST_W-1:0]         ts_sum_t,
  input  logic [STT_W-1:0]        ts_sum_tt,
  input  logic                    frame_start,
  input  logic                    in_valid,
  input  logic [CH_W-1:0]         in_ch,
  input  logic [BIN_W-1:0]        in_bin,
  input  logic [XW-1:0]           in_val,
  input  logic                    in_last,
  output logic                    done,
  output logic [TSEL_W-1:0]       best_idx,
  output logic signed [NUM_W-1:0] best_num
);
  localparam int SX_W  = XW + CL;
  localparam int SXT_W = XW + TW + CL;
  localparam int DEN_W = 2 * TW + 2 * CL;

  logic                          busy;
  logic                          rd_en;
  logic [AW-1:0]                 rd_addr;
  logic                          el_vld, el_clr, el_last;
  logic [XW-1:0]                 el_x;
  logic [SX_W-1:0]               sum_x;
  logic [NUM_TMPL-1:0][SXT_W-1:0] sum_xt;
  logic [NUM_TMPL-1:0][ST_W-1:0]  sum_t;
  logic [NUM_TMPL-1:0][STT_W-1:0] sum_tt;
  phase_e                        phase;
  logic                          ranking, reporting;

  assign ranking   = (phase != PH_ACCUM);
  assign reporting = (phase == PH_REPORT);

  tc_input_stage #(
    .NUM_CH(NUM_CH), .NUM_BINS(NUM_BINS), .XW(XW), .AW(AW),
    .CH_W(CH_W), .BIN_W(BIN_W), .SX_W(SX_W)
  ) u_in (
    .clk(clk), .rst(rst), .busy(busy), .frame_start(frame_start),
    .in_valid(in_valid), .in_ch(in_ch), .in_bin(in_bin), .in_val(in_val), .in_last(in_last),
    .rd_en(rd_en), .rd_addr(rd_addr), .el_vld(el_vld), .el_clr(el_clr),
    .el_last(el_last), .el_x(el_x), .sum_x(sum_x)
  );

  for (genvar g = 0; g < NUM_TMPL; g++) begin : g_pe
    logic wsel, ssel;
    assign wsel = tw_en && (int'(tw_sel) == g);
    assign ssel = ts_en && (int'(ts_sel) == g);
    tc_pe #(
      .N_ELEM(N_ELEM), .XW(XW), .TW(TW), .AW(AW),
      .SXT_W(SXT_W), .ST_W(ST_W), .STT_W(STT_W)
    ) u_pe (
      .clk(clk), .rst(rst), .wr_en(wsel), .wr_addr(tw_addr), .wr_data(tw_data),
      .st_en(ssel), .st_sum_t(ts_sum_t), .st_sum_tt(ts_sum_tt),
      .rd_en(rd_en), .rd_addr(rd_addr), .el_vld(el_vld), .el_clr(el_clr), .el_x(el_x),
      .sum_xt(sum_xt[g]), .sum_t(sum_t[g]), .sum_tt(sum_tt[g])
    );
  end

  tc_ranker #(
    .NT(NUM_TMPL), .N_ELEM(N_ELEM), .TSEL_W(TSEL_W), .SX_W(SX_W), .SXT_W(SXT_W),
    .ST_W(ST_W), .STT_W(STT_W), .NUM_W(NUM_W), .DEN_W(DEN_W)
  ) u_rank (
    .clk(clk), .rst(rst), .start(el_vld && el_last), .sum_x(sum_x),
    .sum_xt(sum_xt), .sum_t(sum_t), .sum_tt(sum_tt),
    .busy(busy), .phase_o(phase), .done(done), .best_idx(best_idx), .best_num(best_num)
  );
endmodule

// File: rtl/tc_correlator_chk.sv
`timescale 1ns/1ps
module tc_correlator_chk #(
  parameter int NUM_TMPL = 4,
  parameter int TSEL_W   = 2,
  parameter int NUM_W    = 17,
  parameter int SX_W     = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    done,
  input logic [TSEL_W-1:0]       best_idx,
  input logic signed [NUM_W-1:0] best_num,
  input logic                    ranking,
  input logic                    reporting,
  input logic [SX_W-1:0]         sum_x
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R7
  AST_DONE_AFTER_REPORT: assert property (@(posedge clk) disable iff (rst) done |-> $past(reporting)); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst) !done |-> ($stable(best_idx) && $stable(best_num))); // R7
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst) done |-> (int'(best_idx) < NUM_TMPL)); // R4
  AST_SUMS_FROZEN: assert property (@(posedge clk) disable iff (rst) ranking |=> $stable(sum_x)); // R10
endmodule

bind tc_correlator tc_correlator_chk #(
  .NUM_TMPL(NUM_TMPL), .TSEL_W(TSEL_W), .NUM_W(NUM_W), .SX_W(XW + CL)
) u_chk (
  .clk(clk), .rst(rst), .done(done), .best_idx(best_idx), .best_num(best_num),
  .ranking(ranking), .reporting(reporting), .sum_x(sum_x)
);

// File: tb/tb_tc_correlator.sv
`timescale 1ns/1ps
module tb_tc_correlator;
  localparam int NT = 4, NCH = 3, NB = 4, NE = NCH * NB;
  localparam int CL = $clog2(NE + 1);
  localparam int NUM_W = 4 + 4 + 2 * CL + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic              tw_en, ts_en, frame_start, in_valid, in_last, done;
  logic [1:0]        tw_sel, ts_sel, in_ch, in_bin, best_idx;
  logic [3:0]        tw_addr, tw_data, in_val;
  logic [4+CL-1:0]   ts_sum_t;
  logic [8+CL-1:0]   ts_sum_tt;
  logic signed [NUM_W-1:0] best_num;

  tc_correlator dut (
    .clk(clk), .rst(rst), .tw_en(tw_en), .tw_sel(tw_sel), .tw_addr(tw_addr), .tw_data(tw_data),
    .ts_en(ts_en), .ts_sel(ts_sel), .ts_sum_t(ts_sum_t), .ts_sum_tt(ts_sum_tt),
    .frame_start(frame_start), .in_valid(in_valid), .in_ch(in_ch), .in_bin(in_bin),
    .in_val(in_val), .in_last(in_last), .done(done), .best_idx(best_idx), .best_num(best_num)
  );

  int n_chk = 0, n_fail = 0;
  int tmem [NT][NE];
  int xv [NE];
  logic [15:0] lfsr = 16'hACE1;

  function automatic int rnd4();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return int'(lfsr[3:0]);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive_zero();
    frame_start = 0; in_valid = 0; in_last = 0; in_ch = '0; in_bin = '0; in_val = '0;
    tw_en = 0; ts_en = 0; tw_sel = '0; ts_sel = '0; tw_addr = '0; tw_data = '0;
    ts_sum_t = '0; ts_sum_tt = '0;
  endtask

  task automatic drive_junk();
    drive_zero();
    frame_start = 1; in_valid = 1; in_val = 4'd15; in_last = 1;
  endtask

  task automatic load_all();
    for (int k = 0; k < NT; k++) begin
      int st = 0, stt = 0;
      for (int e = 0; e < NE; e++) begin
        @(negedge clk); drive_zero();
        tw_en = 1; tw_sel = 2'(k); tw_addr = 4'(e); tw_data = 4'(tmem[k][e]);
        st += tmem[k][e]; stt += tmem[k][e] * tmem[k][e];
      end
      @(negedge clk); drive_zero();
      ts_en = 1; ts_sel = 2'(k); ts_sum_t = (4+CL)'(st); ts_sum_tt = (8+CL)'(stt);
    end
    @(negedge clk); drive_zero();
  endtask

  // reference: real-valued correlation, highest wins, lower index on equality
  function automatic void model(output int bi, output longint bn);
    longint sx = 0;
    longint nm [NT];
    real r [NT];
    for (int e = 0; e < NE; e++) sx += xv[e];
    for (int k = 0; k < NT; k++) begin
      longint sxt = 0, st = 0, stt = 0;
      real dn;
      for (int e = 0; e < NE; e++) begin
        sxt += xv[e] * tmem[k][e]; st += tmem[k][e]; stt += tmem[k][e] * tmem[k][e];
      end
      nm[k] = NE * sxt - sx * st;
      dn = real'(NE * stt - st * st);
      r[k] = (dn > 0.0) ? real'(nm[k]) / $sqrt(dn) : 0.0;
    end
    bi = 0;
    for (int k = 1; k < NT; k++) if (r[k] > r[bi] + 1e-9) bi = k;
    bn = nm[bi];
  endfunction

  // fs_mode: 0 separate frame_start cycle, 1 with first element, 2 none
  task automatic send_frame(input int fs_mode, input bit sparse, input bit gaps);
    bit first = 1;
    if (fs_mode == 0) begin @(negedge clk); drive_zero(); frame_start = 1; end
    for (int e = 0; e < NE; e++) begin
      if (sparse && xv[e] == 0 && e != NE - 1) continue;
      @(negedge clk); drive_zero();
      in_valid = 1; in_ch = 2'(e % NCH); in_bin = 2'(e / NCH); in_val = 4'(xv[e]);
      in_last = (e == NE - 1); frame_start = (fs_mode == 1) && first;
      first = 0;
      if (gaps && (e % 4 == 1)) begin @(negedge clk); drive_zero(); end
    end
  endtask

  task automatic wait_done(input bit junk, output int lat);
    lat = 0;
    @(negedge clk);
    if (junk) drive_junk(); else drive_zero();
    while (!done && lat < 40) begin
      @(negedge clk); lat++;
      if (!done) begin if (junk) drive_junk(); else drive_zero(); end
    end
    drive_zero();
  endtask

  task automatic check_result(input int lat, input string tag);
    int ei; longint en;
    model(ei, en);
    chk(lat == NT + 2, "R7 latency", lat, NT + 2);
    chk(int'(best_idx) == ei, {tag, " index"}, best_idx, ei);
    chk(longint'(best_num) == en, "R3 numerator", longint'(best_num), en);
    @(negedge clk);
    chk(done == 1'b0, "R7 pulse width", done, 0);
  endtask

  task automatic run_frame(input int fs_mode, input bit sparse, input bit gaps, input bit junk,
                           input string tag);
    int lat;
    send_frame(fs_mode, sparse, gaps);
    wait_done(junk, lat);
    check_result(lat, tag);
  endtask

  task automatic rand_tmpl();
    for (int k = 0; k < NT; k++) for (int e = 0; e < NE; e++) tmem[k][e] = rnd4();
  endtask

  task automatic rand_x(input bit many_zero);
    for (int e = 0; e < NE; e++) begin
      xv[e] = rnd4();
      if (many_zero && (lfsr[5:4] != 2'b00)) xv[e] = 0;
    end
  endtask

  initial begin
    drive_zero();
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(best_idx == 2'd0, "R1 index", best_idx, 0);
    chk(best_num == '0, "R1 numerator", best_num, 0);

    // random sweep over frame shapes
    for (int f = 0; f < 48; f++) begin
      if (f % 8 == 0) begin rand_tmpl(); load_all(); end
      rand_x(f % 3 == 2);
      run_frame((f % 4 == 1) ? 1 : 0, f % 3 == 2, f % 2 == 1, 1'b0, (f % 4 == 1) ? "R8" : "R4");
    end

    // exact copy of the input stored in template 2
    for (int e = 0; e < NE; e++) xv[e] = (e * 5 + 3) % 16;
    rand_tmpl();
    for (int e = 0; e < NE; e++) tmem[2][e] = xv[e];
    load_all();
    run_frame(0, 0, 0, 0, "R2");

    // identical best templates at 1 and 3
    for (int e = 0; e < NE; e++) begin tmem[1][e] = xv[e]; tmem[3][e] = xv[e]; end
    load_all();
    run_frame(1, 0, 1, 0, "R6");

    // constant template (zero numerator) at 3 against anti-correlated 0..2
    for (int e = 0; e < NE; e++) begin
      tmem[0][e] = 15 - xv[e];
      tmem[1][e] = (15 - xv[e] + ((e % 3 == 0) ? 3 : 0)) % 16;
      tmem[2][e] = (15 - xv[e]) / 2;
      tmem[3][e] = 7;
    end
    load_all();
    run_frame(0, 0, 0, 0, "R5");

    // all negative: least negative correlation wins
    for (int e = 0; e < NE; e++) tmem[3][e] = (15 - xv[e] + ((e % 2 == 0) ? 6 : 0)) % 16;
    load_all();
    run_frame(0, 0, 0, 0, "R5");

    // strobes during ranking, then a zero-valued re-rank of the same sums
    rand_tmpl(); load_all(); rand_x(1'b0);
    run_frame(0, 0, 0, 1, "R10");
    begin
      int lat;
      @(negedge clk); drive_zero();
      in_valid = 1; in_ch = 2'd0; in_bin = 2'd0; in_val = 4'd0; in_last = 1;
      wait_done(0, lat);
      check_result(lat, "R10");
    end

    // out-of-range channel carrying the last flag
    begin
      int seen = 0;
      rand_x(1'b0);
      @(negedge clk); drive_zero(); frame_start = 1;
      @(negedge clk); drive_zero();
      in_valid = 1; in_ch = 2'd3; in_bin = 2'd1; in_val = 4'd15; in_last = 1;
      @(negedge clk); drive_zero();
      repeat (12) begin @(negedge clk); if (done) seen++; end
      chk(seen == 0, "R9 no result", seen, 0);
      run_frame(2, 0, 0, 0, "R9");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R7 watchdog: actual 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule